// File: doc/BRIEF.md
# Fetch Thread Status Controller

This block tracks the fetch condition of every hardware thread in a multithreaded front end. Each thread owns a small state machine and four sticky stall flags, one per downstream stage (decode, rename, issue/execute, commit). Every cycle the controller folds that thread's incoming events into a single next state, in a fixed priority order. These events are block and unblock pulses, squash requests from commit and from decode, instruction-cache wait and completion events, and trap and quiesce events.

A squash carries a redirect address. The controller writes it into the thread's fetch address register and derives the two follow-on addresses from the instruction size. It also drives a stage-active flag, which tells the surrounding core that at least one enabled thread has fetch work to do.

All pins are plain per-cycle control and status signals. No data stream crosses the block edge, so it has no valid/ready handshake and never applies back-pressure. Per-thread vectors put thread t at bit t. Multi-bit per-thread buses put thread t at bits [t*W +: W].

Top module: `fetch_status_ctrl`

## Requirements
- R1: Each thread's status is a 4-bit code with these values: Running=0, Idle=1, Squashing=2, Blocked=3, WaitResponse=4, WaitRetry=5, FillDone=6, Trap=7, Quiesced=8. While reset is low, every thread reads Running (0), all stall flags are clear, pc is RESET_PC, npc is RESET_PC+INST_BYTES, nnpc is RESET_PC+2*INST_BYTES, and stage_active is high when active threads exist.
- R2: A block pulse from a stage sets that stage's sticky flag for the thread. An unblock pulse clears it. An unblock is legal only while the flag is set and the matching block pulse is absent. A thread stays stalled while any of its four flags remains set.
- R3: A commit squash on an active thread moves it to Squashing (2) on the next edge, even from WaitResponse (4) or WaitRetry (5). It loads pc with the commit redirect address, npc with that address plus INST_BYTES, and nnpc with that address plus 2*INST_BYTES.
- R4: While commit reports that its reorder buffer is still squashing, the active thread is held in Squashing (2).
- R5: A decode squash moves a thread that is not in Squashing (2) into Squashing and loads the decode redirect address into pc, npc and nnpc as in R3. A thread already in Squashing ignores it, and its pc is unchanged.
- R6: A set stall flag, or the global ctx_switch input, sends the thread to Blocked (3) from any state except WaitResponse (4) and WaitRetry (5), which keep their state.
- R7: When a cycle brings no squash, reorder-buffer squash or stall, a thread in Blocked (3) or Squashing (2) returns to Running (0).
- R8: From Running (0), miss_nack leads to WaitRetry (5) and miss_issue leads to WaitResponse (4). From WaitRetry, retry_ok leads to WaitResponse. Priority from Running is trap, then quiesce, then nack, then issue.
- R9: fill_done in WaitResponse (4) leads to Blocked (3) if the thread is stalled and to FillDone (6) otherwise. fill_done in any other state has no effect.
- R10: FillDone (6) holds until fetch_select is high for the thread, and then becomes Running (0).
- R11: trap_evt in Running (0) leads to Trap (7), which only a squash leaves. quiesce_evt in Running leads to Quiesced (8), which wake_evt returns to Running.
- R12: A thread whose active_mask bit is low goes to Idle (1) regardless of other inputs, and a squash has no effect on its pc. An Idle thread that is active again goes to Running (0).
- R13: stage_active is high exactly when some thread with its active_mask bit set shows Running (0), Squashing (2) or FillDone (6).
- R14: When commit and decode squash the same thread in the same cycle, the commit redirect address is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_mask | input | NTHREADS | Thread enabled for fetch |
| ctx_switch | input | 1 | Global context-switch stall |
| blk_dec | input | NTHREADS | Decode block pulse |
| unblk_dec | input | NTHREADS | Decode unblock pulse |
| blk_ren | input | NTHREADS | Rename block pulse |
| unblk_ren | input | NTHREADS | Rename unblock pulse |
| blk_exe | input | NTHREADS | Issue/execute block pulse |
| unblk_exe | input | NTHREADS | Issue/execute unblock pulse |
| blk_cmt | input | NTHREADS | Commit block pulse |
| unblk_cmt | input | NTHREADS | Commit unblock pulse |
| cmt_squash | input | NTHREADS | Squash request from commit |
| cmt_rob_busy | input | NTHREADS | Commit reorder buffer still squashing |
| cmt_redirect_pc | input | NTHREADS*PC_W | Commit redirect address per thread |
| dec_squash | input | NTHREADS | Squash request from decode |
| dec_redirect_pc | input | NTHREADS*PC_W | Decode redirect address per thread |
| miss_issue | input | NTHREADS | Cache access accepted, awaiting response |
| miss_nack | input | NTHREADS | Cache access refused, retry needed |
| retry_ok | input | NTHREADS | Refused access now accepted |
| fill_done | input | NTHREADS | Cache response arrived |
| fetch_select | input | NTHREADS | Thread picked by the fetch arbiter |
| trap_evt | input | NTHREADS | Fetch fault raised |
| quiesce_evt | input | NTHREADS | Quiesce instruction seen |
| wake_evt | input | NTHREADS | Wake from quiesce |
| status_o | output | NTHREADS*4 | Per-thread status code |
| pc_o | output | NTHREADS*PC_W | Fetch address |
| npc_o | output | NTHREADS*PC_W | Next fetch address |
| nnpc_o | output | NTHREADS*PC_W | Next-next fetch address |
| stage_active | output | 1 | Any enabled thread has fetch work |

## Verification
The hardest situation to reach is a cache response that arrives while a thread waits on the cache and also holds a stall flag. The wait state hides the stall, so the status shows nothing until the response lands. The stimulus first issues a miss, then sends an execute block pulse while the thread waits, which leaves the status at WaitResponse. Only then does it deliver fill_done, and it expects Blocked instead of FillDone. A second hard case is a decode squash on a thread that a reorder-buffer squash already holds in Squashing. The bench checks that the decode address does not reach pc.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int ST_W = 4;
  localparam int NSRC = 4;

  typedef enum logic [ST_W-1:0] {
    FS_RUN        = 4'd0,
    FS_IDLE       = 4'd1,
    FS_SQUASH     = 4'd2,
    FS_BLOCKED    = 4'd3,
    FS_WAIT_RESP  = 4'd4,
    FS_WAIT_RETRY = 4'd5,
    FS_FILL_DONE  = 4'd6,
    FS_TRAP       = 4'd7,
    FS_QUIESCE    = 4'd8
  } fstate_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CMT  = 2'd1,
    RD_DEC  = 2'd2
  } redir_e;

  typedef struct packed {
    logic cmt_sq;
    logic rob_busy;
    logic dec_sq;
    logic miss_issue;
    logic miss_nack;
    logic retry_ok;
    logic fill_done;
    logic select;
    logic trap;
    logic quiesce;
    logic wake;
  } fevents_t;

  function automatic logic fs_is_live(fstate_e s);
    return (s == FS_RUN) || (s == FS_SQUASH) || (s == FS_FILL_DONE);
  endfunction

endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] blk_i,
  input  logic [NSRC-1:0] unblk_i,
  output logic [NSRC-1:0] flags_q_o,
  output logic [NSRC-1:0] flags_nx_o
);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic flag_q;
    logic flag_nx;

    // unblock wins; a set flag stays set until its own unblock
    always_comb begin
      flag_nx = flag_q;
      if (blk_i[s])   flag_nx = 1'b1;
      if (unblk_i[s]) flag_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_nx;
    end

    assign flags_q_o[s]  = flag_q;
    assign flags_nx_o[s] = flag_nx;
  end

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active_i,
  input  logic     stall_i,
  input  fevents_t ev_i,
  output fstate_e  state_o,
  output redir_e   redir_o
);

  fstate_e st_q;
  fstate_e st_nx;
  logic    in_wait;

  assign in_wait = (st_q == FS_WAIT_RESP) || (st_q == FS_WAIT_RETRY);

  // Fixed priority: enable, commit squash, ROB squash, decode squash,
  // stall, release, then per-state events.
  always_comb begin
    st_nx   = st_q;
    redir_o = RD_NONE;
    if (!active_i) begin
      st_nx = FS_IDLE;
    end else if (ev_i.cmt_sq) begin
      st_nx   = FS_SQUASH;
      redir_o = RD_CMT;
    end else if (ev_i.rob_busy) begin
      st_nx = FS_SQUASH;
    end else if (ev_i.dec_sq) begin
      if (st_q != FS_SQUASH) begin
        st_nx   = FS_SQUASH;
        redir_o = RD_DEC;
      end
    end else if (stall_i && !in_wait) begin
      st_nx = FS_BLOCKED;
    end else if (st_q == FS_BLOCKED || st_q == FS_SQUASH) begin
      st_nx = FS_RUN;
    end else begin
      case (st_q)
        FS_RUN: begin
          if (ev_i.trap)            st_nx = FS_TRAP;
          else if (ev_i.quiesce)    st_nx = FS_QUIESCE;
          else if (ev_i.miss_nack)  st_nx = FS_WAIT_RETRY;
          else if (ev_i.miss_issue) st_nx = FS_WAIT_RESP;
        end
        FS_IDLE:       st_nx = FS_RUN;
        FS_WAIT_RESP: begin
          if (ev_i.fill_done) st_nx = stall_i ? FS_BLOCKED : FS_FILL_DONE;
        end
        FS_WAIT_RETRY: begin
          if (ev_i.retry_ok) st_nx = FS_WAIT_RESP;
        end
        FS_FILL_DONE: begin
          if (ev_i.select) st_nx = FS_RUN;
        end
        FS_QUIESCE: begin
          if (ev_i.wake) st_nx = FS_RUN;
        end
        default: st_nx = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FS_RUN;
    else        st_q <= st_nx;
  end

  assign state_o = st_q;

endmodule

// File: rtl/fsc_pc_track.sv
module fsc_pc_track #(
  parameter int              PC_W       = 32,
  parameter int              INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = 'h1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o,
  output logic [PC_W-1:0] nnpc_o
);

  localparam logic [PC_W-1:0] STEP1 = PC_W'(INST_BYTES);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * INST_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o   <= RESET_PC;
      npc_o  <= RESET_PC + STEP1;
      nnpc_o <= RESET_PC + STEP2;
    end else if (load_i) begin
      pc_o   <= load_pc_i;
      npc_o  <= load_pc_i + STEP1;
      nnpc_o <= load_pc_i + STEP2;
    end
  end

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int              NTHREADS   = 4,
  parameter int              PC_W       = 32,
  parameter int              INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = 'h1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTHREADS-1:0]      active_mask,
  input  logic                     ctx_switch,
  input  logic [NTHREADS-1:0]      blk_dec,
  input  logic [NTHREADS-1:0]      unblk_dec,
  input  logic [NTHREADS-1:0]      blk_ren,
  input  logic [NTHREADS-1:0]      unblk_ren,
  input  logic [NTHREADS-1:0]      blk_exe,
  input  logic [NTHREADS-1:0]      unblk_exe,
  input  logic [NTHREADS-1:0]      blk_cmt,
  input  logic [NTHREADS-1:0]      unblk_cmt,
  input  logic [NTHREADS-1:0]      cmt_squash,
  input  logic [NTHREADS-1:0]      cmt_rob_busy,
  input  logic [NTHREADS*PC_W-1:0] cmt_redirect_pc,
  input  logic [NTHREADS-1:0]      dec_squash,
  input  logic [NTHREADS*PC_W-1:0] dec_redirect_pc,
  input  logic [NTHREADS-1:0]      miss_issue,
  input  logic [NTHREADS-1:0]      miss_nack,
  input  logic [NTHREADS-1:0]      retry_ok,
  input  logic [NTHREADS-1:0]      fill_done,
  input  logic [NTHREADS-1:0]      fetch_select,
  input  logic [NTHREADS-1:0]      trap_evt,
  input  logic [NTHREADS-1:0]      quiesce_evt,
  input  logic [NTHREADS-1:0]      wake_evt,
  output logic [NTHREADS*ST_W-1:0] status_o,
  output logic [NTHREADS*PC_W-1:0] pc_o,
  output logic [NTHREADS*PC_W-1:0] npc_o,
  output logic [NTHREADS*PC_W-1:0] nnpc_o,
  output logic                     stage_active
);

  localparam int FLAG_W = NTHREADS * NSRC;

  logic [FLAG_W-1:0]   stall_flags;
  logic [NTHREADS-1:0] live;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    logic [NSRC-1:0] blk_v;
    logic [NSRC-1:0] unblk_v;
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] flags_nx;
    logic            stall_any;
    fevents_t        ev;
    fstate_e         st;
    redir_e          rd;
    logic            load;
    logic [PC_W-1:0] load_pc;

    // source order inside a thread: bit0 decode, bit1 rename, bit2 exe, bit3 commit
    assign blk_v   = {blk_cmt[t], blk_exe[t], blk_ren[t], blk_dec[t]};
    assign unblk_v = {unblk_cmt[t], unblk_exe[t], unblk_ren[t], unblk_dec[t]};

    fsc_stall_flags #(.NSRC(NSRC)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_i     (blk_v),
      .unblk_i   (unblk_v),
      .flags_q_o (flags_q),
      .flags_nx_o(flags_nx)
    );

    assign stall_any = (|flags_nx) | ctx_switch;

    assign ev.cmt_sq     = cmt_squash[t];
    assign ev.rob_busy   = cmt_rob_busy[t];
    assign ev.dec_sq     = dec_squash[t];
    assign ev.miss_issue = miss_issue[t];
    assign ev.miss_nack  = miss_nack[t];
    assign ev.retry_ok   = retry_ok[t];
    assign ev.fill_done  = fill_done[t];
    assign ev.select     = fetch_select[t];
    assign ev.trap       = trap_evt[t];
    assign ev.quiesce    = quiesce_evt[t];
    assign ev.wake       = wake_evt[t];

    fsc_thread_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .active_i(active_mask[t]),
      .stall_i (stall_any),
      .ev_i    (ev),
      .state_o (st),
      .redir_o (rd)
    );

    assign load    = (rd != RD_NONE);
    assign load_pc = (rd == RD_CMT) ? cmt_redirect_pc[t*PC_W +: PC_W]
                                    : dec_redirect_pc[t*PC_W +: PC_W];

    fsc_pc_track #(
      .PC_W      (PC_W),
      .INST_BYTES(INST_BYTES),
      .RESET_PC  (RESET_PC)
    ) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .load_pc_i(load_pc),
      .pc_o     (pc_o[t*PC_W +: PC_W]),
      .npc_o    (npc_o[t*PC_W +: PC_W]),
      .nnpc_o   (nnpc_o[t*PC_W +: PC_W])
    );

    assign status_o[t*ST_W +: ST_W]       = st;
    assign live[t]                        = fs_is_live(st);
    assign stall_flags[t*NSRC +: NSRC]    = flags_q;
  end

  assign stage_active = |(live & active_mask);

endmodule

// File: rtl/fetch_status_ctrl_chk.sv
module fetch_status_ctrl_chk
  import fsc_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int PC_W     = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NTHREADS-1:0]      active_mask,
  input logic [NTHREADS-1:0]      blk_dec,
  input logic [NTHREADS-1:0]      unblk_dec,
  input logic [NTHREADS-1:0]      blk_ren,
  input logic [NTHREADS-1:0]      unblk_ren,
  input logic [NTHREADS-1:0]      blk_exe,
  input logic [NTHREADS-1:0]      unblk_exe,
  input logic [NTHREADS-1:0]      blk_cmt,
  input logic [NTHREADS-1:0]      unblk_cmt,
  input logic [NTHREADS-1:0]      cmt_squash,
  input logic [NTHREADS-1:0]      cmt_rob_busy,
  input logic [NTHREADS*PC_W-1:0] cmt_redirect_pc,
  input logic [NTHREADS-1:0]      dec_squash,
  input logic [NTHREADS-1:0]      fill_done,
  input logic [NTHREADS*ST_W-1:0] status_o,
  input logic [NTHREADS*PC_W-1:0] pc_o,
  input logic [NTHREADS*NSRC-1:0] stall_flags
);

  for (genvar i = 0; i < NTHREADS; i++) begin : g_chk
    logic [ST_W-1:0] st;
    assign st = status_o[i*ST_W +: ST_W];

    // R2
    unblk_dec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unblk_dec[i] |-> (stall_flags[i*NSRC+0] && !blk_dec[i]));
    // R2
    unblk_ren_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unblk_ren[i] |-> (stall_flags[i*NSRC+1] && !blk_ren[i]));
    // R2
    unblk_exe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unblk_exe[i] |-> (stall_flags[i*NSRC+2] && !blk_exe[i]));
    // R2
    unblk_cmt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unblk_cmt[i] |-> (stall_flags[i*NSRC+3] && !blk_cmt[i]));

    // R3
    cmt_squash_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_mask[i] && cmt_squash[i]) |=>
        (st == FS_SQUASH && pc_o[i*PC_W +: PC_W] == $past(cmt_redirect_pc[i*PC_W +: PC_W])));

    // R4
    rob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_mask[i] && cmt_rob_busy[i]) |=> (st == FS_SQUASH));

    // R5
    dec_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_mask[i] && dec_squash[i] && !cmt_squash[i] && st == FS_SQUASH) |=>
        $stable(pc_o[i*PC_W +: PC_W]));

    // R6
    wait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_mask[i] && st == FS_WAIT_RESP && !cmt_squash[i] && !cmt_rob_busy[i]
       && !dec_squash[i] && !fill_done[i]) |=> (st == FS_WAIT_RESP));

    // R12
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_mask[i] |=> (st == FS_IDLE));
  end

endmodule

bind fetch_status_ctrl fetch_status_ctrl_chk #(
  .NTHREADS(NTHREADS),
  .PC_W    (PC_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .active_mask    (active_mask),
  .blk_dec        (blk_dec),
  .unblk_dec      (unblk_dec),
  .blk_ren        (blk_ren),
  .unblk_ren      (unblk_ren),
  .blk_exe        (blk_exe),
  .unblk_exe      (unblk_exe),
  .blk_cmt        (blk_cmt),
  .unblk_cmt      (unblk_cmt),
  .cmt_squash     (cmt_squash),
  .cmt_rob_busy   (cmt_rob_busy),
  .cmt_redirect_pc(cmt_redirect_pc),
  .dec_squash     (dec_squash),
  .fill_done      (fill_done),
  .status_o       (status_o),
  .pc_o           (pc_o),
  .stall_flags    (stall_flags)
);

// File: tb/fetch_status_ctrl_tb_top.sv
module fetch_status_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NT   = 4;
  localparam int PW   = 32;
  localparam int SW   = 4;

  localparam int S_RUN = 0, S_IDLE = 1, S_SQ = 2, S_BLK = 3, S_WRESP = 4,
                 S_WRETRY = 5, S_FILL = 6, S_TRAP = 7, S_QUI = 8;
  localparam int K_ST = 0, K_PC = 1, K_NPC = 2, K_NNPC = 3, K_ACT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] active_mask = '1;
  logic ctx_switch = 1'b0;
  logic [NT-1:0] blk_dec, unblk_dec, blk_ren, unblk_ren;
  logic [NT-1:0] blk_exe, unblk_exe, blk_cmt, unblk_cmt;
  logic [NT-1:0] cmt_squash, cmt_rob_busy, dec_squash;
  logic [NT*PW-1:0] cmt_redirect_pc = '0;
  logic [NT*PW-1:0] dec_redirect_pc = '0;
  logic [NT-1:0] miss_issue, miss_nack, retry_ok, fill_done;
  logic [NT-1:0] fetch_select, trap_evt, quiesce_evt, wake_evt;
  logic [NT*SW-1:0] status_o;
  logic [NT*PW-1:0] pc_o, npc_o, nnpc_o;
  logic stage_active;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_status_ctrl #(.NTHREADS(NT), .PC_W(PW), .INST_BYTES(4), .RESET_PC(32'h1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .active_mask(active_mask), .ctx_switch(ctx_switch),
    .blk_dec(blk_dec), .unblk_dec(unblk_dec), .blk_ren(blk_ren), .unblk_ren(unblk_ren),
    .blk_exe(blk_exe), .unblk_exe(unblk_exe), .blk_cmt(blk_cmt), .unblk_cmt(unblk_cmt),
    .cmt_squash(cmt_squash), .cmt_rob_busy(cmt_rob_busy), .cmt_redirect_pc(cmt_redirect_pc),
    .dec_squash(dec_squash), .dec_redirect_pc(dec_redirect_pc),
    .miss_issue(miss_issue), .miss_nack(miss_nack), .retry_ok(retry_ok),
    .fill_done(fill_done), .fetch_select(fetch_select), .trap_evt(trap_evt),
    .quiesce_evt(quiesce_evt), .wake_evt(wake_evt),
    .status_o(status_o), .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .stage_active(stage_active)
  );

  typedef struct {
    int          due;
    int          kind;
    int          tid;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [31:0] observe(int kind, int t);
    case (kind)
      K_ST:    return 32'(status_o[t*SW +: SW]);
      K_PC:    return pc_o[t*PW +: PW];
      K_NPC:   return npc_o[t*PW +: PW];
      K_NNPC:  return nnpc_o[t*PW +: PW];
      default: return 32'(stage_active);
    endcase
  endfunction

  // monitor: compares queued expectations shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        logic [31:0] got;
        e = q.pop_front();
        got = observe(e.kind, e.tid);
        checks++;
        if (got !== e.val) begin
          fails++;
          $display("FAIL %s kind=%0d thread=%0d got=%h exp=%h", e.tag, e.kind, e.tid, got, e.val);
        end
      end
    end
  end

  task automatic push(int kind, int t, logic [31:0] v, string tag);
    exp_t e;
    e.due = cyc + 1; e.kind = kind; e.tid = t; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_st(int t, int s, string tag);
    push(K_ST, t, 32'(s), tag);
  endtask

  task automatic exp_pcs(int t, logic [31:0] base, string tag);
    push(K_PC, t, base, tag);
    push(K_NPC, t, base + 32'd4, tag);
    push(K_NNPC, t, base + 32'd8, tag);
  endtask

  task automatic nxt();
    @(negedge clk);
    ctx_switch = 1'b0;
    {blk_dec, unblk_dec, blk_ren, unblk_ren} = '0;
    {blk_exe, unblk_exe, blk_cmt, unblk_cmt} = '0;
    {cmt_squash, cmt_rob_busy, dec_squash} = '0;
    {miss_issue, miss_nack, retry_ok, fill_done} = '0;
    {fetch_select, trap_evt, quiesce_evt, wake_evt} = '0;
  endtask

  initial begin
    nxt();
    nxt();
    // R1 reset state
    for (int t = 0; t < NT; t++) exp_st(t, S_RUN, "R1");
    exp_pcs(0, 32'h1000, "R1");
    push(K_ACT, 0, 32'd1, "R1");
    nxt(); rst_n = 1'b1; blk_dec[0] = 1'b1;
    exp_st(0, S_BLK, "R6"); exp_st(1, S_RUN, "R2");
    nxt(); exp_st(0, S_BLK, "R2");
    nxt(); unblk_dec[0] = 1'b1; exp_st(0, S_RUN, "R7");
    nxt(); blk_cmt[1] = 1'b1; blk_ren[1] = 1'b1; exp_st(1, S_BLK, "R2");
    nxt(); unblk_cmt[1] = 1'b1; exp_st(1, S_BLK, "R2");
    nxt(); unblk_ren[1] = 1'b1; exp_st(1, S_RUN, "R7");
    nxt(); ctx_switch = 1'b1;
    for (int t = 0; t < NT; t++) exp_st(t, S_BLK, "R6");
    push(K_ACT, 0, 32'd0, "R13");
    nxt();
    for (int t = 0; t < NT; t++) exp_st(t, S_RUN, "R7");
    push(K_ACT, 0, 32'd1, "R13");
    // stalled fill
    nxt(); miss_issue[0] = 1'b1; exp_st(0, S_WRESP, "R8");
    nxt(); blk_exe[0] = 1'b1; exp_st(0, S_WRESP, "R6");
    nxt(); fill_done[0] = 1'b1; exp_st(0, S_BLK, "R9");
    nxt(); unblk_exe[0] = 1'b1; exp_st(0, S_RUN, "R7");
    // clean fill
    nxt(); miss_issue[0] = 1'b1; exp_st(0, S_WRESP, "R8");
    nxt(); fill_done[0] = 1'b1; exp_st(0, S_FILL, "R9");
    nxt(); exp_st(0, S_FILL, "R10");
    nxt(); fetch_select[0] = 1'b1; exp_st(0, S_RUN, "R10");
    // retry path, squash cancels wait
    nxt(); miss_nack[2] = 1'b1; exp_st(2, S_WRETRY, "R8");
    nxt(); retry_ok[2] = 1'b1; exp_st(2, S_WRESP, "R8");
    nxt(); cmt_squash[2] = 1'b1; cmt_redirect_pc[2*PW +: PW] = 32'h2000;
    exp_st(2, S_SQ, "R3"); exp_pcs(2, 32'h2000, "R3");
    nxt(); exp_st(2, S_RUN, "R7");
    nxt(); fill_done[2] = 1'b1; exp_st(2, S_RUN, "R9");
    // ROB squash hold, decode ignored
    nxt(); cmt_squash[1] = 1'b1; cmt_rob_busy[1] = 1'b1; cmt_redirect_pc[PW +: PW] = 32'h3000;
    exp_st(1, S_SQ, "R3"); exp_pcs(1, 32'h3000, "R3");
    nxt(); cmt_rob_busy[1] = 1'b1; exp_st(1, S_SQ, "R4");
    nxt(); dec_squash[1] = 1'b1; dec_redirect_pc[PW +: PW] = 32'h4444;
    exp_st(1, S_SQ, "R5"); push(K_PC, 1, 32'h3000, "R5");
    nxt(); exp_st(1, S_RUN, "R7");
    // decode squash applied
    nxt(); dec_squash[3] = 1'b1; dec_redirect_pc[3*PW +: PW] = 32'h5000;
    exp_st(3, S_SQ, "R5"); exp_pcs(3, 32'h5000, "R5");
    nxt(); exp_st(3, S_RUN, "R7");
    // both squash sources
    nxt(); cmt_squash[3] = 1'b1; dec_squash[3] = 1'b1;
    cmt_redirect_pc[3*PW +: PW] = 32'h6000; dec_redirect_pc[3*PW +: PW] = 32'h7000;
    exp_st(3, S_SQ, "R14"); exp_pcs(3, 32'h6000, "R14");
    nxt(); exp_st(3, S_RUN, "R7");
    // trap and quiesce
    nxt(); trap_evt[0] = 1'b1; exp_st(0, S_TRAP, "R11");
    nxt(); wake_evt[0] = 1'b1; exp_st(0, S_TRAP, "R11");
    nxt(); cmt_squash[0] = 1'b1; cmt_redirect_pc[0 +: PW] = 32'h0100;
    exp_st(0, S_SQ, "R11"); exp_pcs(0, 32'h0100, "R11");
    nxt(); exp_st(0, S_RUN, "R7");
    nxt(); quiesce_evt[0] = 1'b1; exp_st(0, S_QUI, "R11");
    nxt(); wake_evt[0] = 1'b1; exp_st(0, S_RUN, "R11");
    // enable mask
    nxt(); active_mask = '0;
    for (int t = 0; t < NT; t++) exp_st(t, S_IDLE, "R12");
    push(K_ACT, 0, 32'd0, "R13");
    nxt(); active_mask = 4'b0001;
    exp_st(0, S_RUN, "R12"); exp_st(1, S_IDLE, "R12");
    push(K_ACT, 0, 32'd1, "R13");
    nxt(); cmt_squash[1] = 1'b1; cmt_redirect_pc[PW +: PW] = 32'h9000;
    exp_st(1, S_IDLE, "R12"); push(K_PC, 1, 32'h3000, "R12");
    nxt();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before end of stimulus");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule